// File: doc/BRIEF.md
# Flash Read-Mode Controller

This block is the read-path controller of a parallel NOR flash command interface. It watches the bus strobes. These are three chip enables, an output enable and a write enable. It decodes the command bytes written on the low data byte into one of three read modes: memory array, status register and identifier. Each bus read then returns the data word that matches the current mode. Every data pin has its own enable, so the pins are driven one by one or left high-impedance.

A small write-state-machine stub feeds the status inputs: a busy flag and six flag bits such as error and suspend indications. The status word is captured when a read starts and is held until that read ends. A host that polls status therefore sees a value that does not change in the middle of an access. While the captured word says an operation is running, only the ready bit is driven. All strobes are sampled on `clk`, and the data and pin-enable outputs are registered, so each output reflects the inputs one clock earlier.

Top module: `flash_readpath`

## Requirements
- R1: After reset the read mode is array and no data pin is driven (`dq_oe` is 0000h, `dq_out` is 0000h).
- R2: The device is enabled only when `ce0_n` is 0, `ce1_n` is 0 and `ce2` is 1. A read is active while the device is enabled and `oe_n` is 0. `dq_oe` is nonzero one cycle after a sampled active read, and 0000h otherwise.
- R3: A command is taken on a clock where the device is enabled, `we_n` is sampled 0, and it was sampled 1 on the previous clock. The command byte is `din[7:0]`. 70h selects status mode, 90h selects identifier mode and FFh selects array mode. Any other byte leaves the mode unchanged. A mode stays in force across any number of reads.
- R4: The status word is 00h in bits 15:8. Bit 7 is 1 when `wsm_busy` is 0, bits 6:1 equal `wsm_flags[5:0]`, and bit 0 is 0.
- R5: The status word is captured on the clock where a read becomes active, whether `oe_n` falls or the chip enables complete. That clock's output already uses the new capture. The captured word is not refreshed until the read ends.
- R6: In status mode, when the captured bit 7 is 0, only pin 7 is driven (`dq_oe` = 0080h) and it reads 0.
- R7: In status mode, when the captured bit 7 is 1, all 16 pins are driven with the full status word.
- R8: In identifier mode the word offset is `addr[OFF_W-1:1]`. Offset 0 returns 0089h. Offset 1 returns the density code: 0016h for 32 Mbit, 0017h for 64 Mbit, and 0018h for 128 Mbit (the default).
- R9: In identifier mode offset 2 returns `blk_locked` on bit 0 and 0 on bits 15:1. Every other offset returns 0000h.
- R10: In array mode all 16 pins are driven with `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | OFF_W-1 | Word address within a block, bits OFF_W-1 down to 1 |
| din | input | 16 | Write data; the command byte is on bits 7:0 |
| wsm_busy | input | 1 | Operation in progress |
| wsm_flags | input | 6 | Status flags from the write state machine |
| blk_locked | input | 1 | Lock state of the addressed block |
| array_data | input | 16 | Word from the memory array |
| dq_out | output | 16 | Data to the pins |
| dq_oe | output | 16 | Per-pin output enable |

## Verification
A wrong mode register is caught on the first read that follows, one clock after the read is sampled. The word that appears comes from the wrong source: array data in place of status, or an identifier code in place of array data. A status capture taken at the wrong moment shows up as a value that changes while a read is held. It can also show up as a stale value when a new read begins. The behavioural model compares every clock, so the error is reported within one cycle. A wrong pin mask while busy shows as driven upper or low pins on that same cycle.

// File: rtl/flash_rp_pkg.sv
package flash_rp_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] MFR_CODE   = 8'h89;

  function automatic logic [7:0] density_code(input int mbit);
    case (mbit)
      32:      return 8'h16;
      64:      return 8'h17;
      default: return 8'h18;
    endcase
  endfunction

  function automatic logic [15:0] pack_status(input logic busy, input logic [5:0] flags);
    return {8'h00, ~busy, flags, 1'b0};
  endfunction

  function automatic rd_mode_e next_mode(input logic [7:0] cmd, input rd_mode_e cur);
    case (cmd)
      CMD_STATUS: return RM_STATUS;
      CMD_IDENT:  return RM_IDENT;
      CMD_ARRAY:  return RM_ARRAY;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/rp_cmd_decode.sv
module rp_cmd_decode
  import flash_rp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enabled,
  input  logic     we_n,
  input  logic [7:0] cmd_byte,
  output rd_mode_e mode
);
  logic we_n_q;
  logic cmd_stb;

  assign cmd_stb = enabled & ~we_n & we_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_n_q <= 1'b1;
      mode   <= RM_ARRAY;
    end else begin
      we_n_q <= we_n;
      if (cmd_stb) mode <= next_mode(cmd_byte, mode);
    end
  end

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> $stable(mode));

endmodule

// File: rtl/rp_status_latch.sv
module rp_status_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        read_on,
  input  logic [15:0] sr_live,
  output logic [15:0] sr_view
);
  logic        read_on_q;
  logic        read_rise;
  logic [15:0] sr_hold;

  assign read_rise = read_on & ~read_on_q;
  assign sr_view   = read_rise ? sr_live : sr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_on_q <= 1'b0;
      sr_hold   <= '0;
    end else begin
      read_on_q <= read_on;
      if (read_rise) sr_hold <= sr_live;
    end
  end

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (read_on && read_on_q) |=> $stable(sr_hold));

endmodule

// File: rtl/rp_id_decode.sv
module rp_id_decode
  import flash_rp_pkg::*;
#(
  parameter int OFF_W        = 6,
  parameter int DENSITY_MBIT = 128
) (
  input  logic [OFF_W-1:1] offset,
  input  logic             blk_locked,
  output logic [15:0]      id_word
);
  localparam logic [7:0] DEV_CODE = density_code(DENSITY_MBIT);

  always_comb begin
    case (offset)
      (OFF_W-1)'(0): id_word = {8'h00, MFR_CODE};
      (OFF_W-1)'(1): id_word = {8'h00, DEV_CODE};
      (OFF_W-1)'(2): id_word = {15'h0000, blk_locked};
      default:       id_word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/flash_readpath.sv
module flash_readpath
  import flash_rp_pkg::*;
#(
  parameter int OFF_W        = 6,
  parameter int DENSITY_MBIT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce0_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [OFF_W-1:1] addr,
  input  logic [15:0]      din,
  input  logic             wsm_busy,
  input  logic [5:0]       wsm_flags,
  input  logic             blk_locked,
  input  logic [15:0]      array_data,
  output logic [15:0]      dq_out,
  output logic [15:0]      dq_oe
);
  localparam logic [15:0] ALL_PINS  = '1;
  localparam logic [15:0] READY_PIN = 16'h0080;

  logic        enabled;
  logic        read_on;
  rd_mode_e    mode;
  logic [15:0] sr_live;
  logic [15:0] sr_view;
  logic [15:0] id_word;
  logic [15:0] data_nxt;
  logic [15:0] mask_nxt;

  assign enabled = ~ce0_n & ~ce1_n & ce2;
  assign read_on = enabled & ~oe_n;
  assign sr_live = pack_status(wsm_busy, wsm_flags);

  rp_cmd_decode u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .enabled  (enabled),
    .we_n     (we_n),
    .cmd_byte (din[7:0]),
    .mode     (mode)
  );

  rp_status_latch u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .read_on (read_on),
    .sr_live (sr_live),
    .sr_view (sr_view)
  );

  rp_id_decode #(.OFF_W(OFF_W), .DENSITY_MBIT(DENSITY_MBIT)) u_id (
    .offset     (addr),
    .blk_locked (blk_locked),
    .id_word    (id_word)
  );

  always_comb begin
    case (mode)
      RM_STATUS: begin
        mask_nxt = sr_view[7] ? ALL_PINS : READY_PIN;
        data_nxt = sr_view & mask_nxt;
      end
      RM_IDENT: begin
        mask_nxt = ALL_PINS;
        data_nxt = id_word;
      end
      default: begin
        mask_nxt = ALL_PINS;
        data_nxt = array_data;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (read_on) begin
      dq_out <= data_nxt;
      dq_oe  <= mask_nxt;
    end else begin
      dq_out <= '0;
      dq_oe  <= '0;
    end
  end

  assert_bus_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !read_on |=> (dq_oe == 16'h0000));

  assert_busy_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_on && mode == RM_STATUS && !sr_view[7]) |=> (dq_oe == READY_PIN && !dq_out[7]));

  assert_ready_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (read_on && mode == RM_STATUS && sr_view[7]) |=> (dq_oe == ALL_PINS && dq_out[15:8] == 8'h00));

endmodule

// File: tb/tb_flash_readpath.sv
`timescale 1ns/1ps
module tb_flash_readpath;
  localparam int OFF_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce0_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [OFF_W-1:1] addr = '0;
  logic [15:0] din = '0;
  logic wsm_busy = 1'b0;
  logic [5:0] wsm_flags = '0;
  logic blk_locked = 1'b0;
  logic [15:0] array_data = '0;
  logic [15:0] dq_out, dq_oe;

  always #2.5 clk = ~clk;

  flash_readpath #(.OFF_W(OFF_W), .DENSITY_MBIT(128)) dut (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2(ce2),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din), .wsm_busy(wsm_busy),
    .wsm_flags(wsm_flags), .blk_locked(blk_locked), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference: 0 array, 1 status, 2 identifier
  int m_mode;
  logic [15:0] m_hold, exp_dq, exp_oe;
  bit m_prev_read, m_prev_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_hold = 0; m_prev_read = 0; m_prev_we = 1;
      exp_dq = 0; exp_oe = 0;
    end else begin
      bit on_chip, reading, starting;
      logic [15:0] live, seen;
      int off;
      on_chip  = (ce0_n == 0) && (ce1_n == 0) && (ce2 == 1);
      reading  = on_chip && (oe_n == 0);
      starting = reading && !m_prev_read;
      live = 16'h0000;
      live[7] = !wsm_busy;
      for (int i = 0; i < 6; i++) live[i+1] = wsm_flags[i];
      seen = starting ? live : m_hold;
      off = int'(addr);
      exp_dq = 0; exp_oe = 0;
      if (reading) begin
        if (m_mode == 1) begin
          if (seen[7]) begin exp_dq = seen; exp_oe = 16'hFFFF; end
          else begin exp_dq = 0; exp_oe = 16'h0080; end
        end else if (m_mode == 2) begin
          exp_oe = 16'hFFFF;
          if (off == 0) exp_dq = 16'h0089;
          else if (off == 1) exp_dq = 16'h0018;
          else if (off == 2) exp_dq = blk_locked ? 16'h0001 : 16'h0000;
          else exp_dq = 16'h0000;
        end else begin
          exp_dq = array_data; exp_oe = 16'hFFFF;
        end
      end
      if (starting) m_hold = live;
      m_prev_read = reading;
      if (on_chip && !we_n && m_prev_we) begin
        if (din[7:0] == 8'h70) m_mode = 1;
        else if (din[7:0] == 8'h90) m_mode = 2;
        else if (din[7:0] == 8'hFF) m_mode = 0;
      end
      m_prev_we = we_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dq_out !== exp_dq || dq_oe !== exp_oe) begin
        failures++;
        $display("FAIL %s: dq_out=%h dq_oe=%h expected dq_out=%h dq_oe=%h",
                 tag, dq_out, dq_oe, exp_dq, exp_oe);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ce0_n = 1; ce1_n = 1; ce2 = 0; oe_n = 1; we_n = 1;
    end
  endtask

  task automatic cmd(logic [7:0] b);
    @(negedge clk); ce0_n = 0; ce1_n = 0; ce2 = 1; oe_n = 1; din = {8'h00, b}; we_n = 0;
    @(negedge clk); we_n = 1;
    idle(1);
  endtask

  task automatic rd(logic [OFF_W-1:1] a, int len);
    @(negedge clk); addr = a; ce0_n = 0; ce1_n = 0; ce2 = 1; oe_n = 0;
    for (int i = 1; i < len; i++) @(negedge clk);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (dq_oe !== 16'h0000 || dq_out !== 16'h0000) begin
      failures++;
      $display("FAIL R1: dq_out=%h dq_oe=%h expected 0000 0000", dq_out, dq_oe);
    end
    rst_n = 1;
    idle(2);
    tag = "R1"; rd(5'd3, 1);                 // array after reset
    tag = "R10";
    array_data = 16'hA5C3; rd(5'd1, 3);
    array_data = 16'h0FF0; rd(5'd7, 2);
    // R2: each enable wrong, then read with oe high
    tag = "R2";
    @(negedge clk); ce0_n = 1; ce1_n = 0; ce2 = 1; oe_n = 0;
    @(negedge clk); ce0_n = 0; ce1_n = 1;
    @(negedge clk); ce1_n = 0; ce2 = 0;
    @(negedge clk); ce2 = 1; oe_n = 1;
    idle(2);
    // R3 and R7 and R4: status, ready, flag patterns
    tag = "R3"; cmd(8'h70);
    tag = "R7"; wsm_busy = 0; wsm_flags = 6'b101101; rd(5'd0, 2);
    tag = "R4"; wsm_flags = 6'b010010; rd(5'd9, 2);
    tag = "R3"; array_data = 16'h1234; rd(5'd2, 2);
    cmd(8'h55); rd(5'd2, 2);                  // unrecognised byte keeps status
    // R6: busy masks
    tag = "R6"; wsm_busy = 1; wsm_flags = 6'b111111; rd(5'd0, 3);
    // R5: capture at start, held while read stays active
    tag = "R5";
    wsm_busy = 0; wsm_flags = 6'b000011;
    @(negedge clk); ce0_n = 0; ce1_n = 0; ce2 = 1; oe_n = 0;
    @(negedge clk); wsm_busy = 1; wsm_flags = 6'b110000;
    @(negedge clk); @(negedge clk);
    idle(1);
    rd(5'd0, 2);                               // new read sees busy
    // R5: enable completes while oe already low
    @(negedge clk); oe_n = 0; ce0_n = 0; ce1_n = 1; ce2 = 1;
    wsm_busy = 0; wsm_flags = 6'b100001;
    @(negedge clk); ce1_n = 0;
    @(negedge clk); wsm_flags = 6'b000000;
    @(negedge clk);
    idle(2);
    // R8 and R9: identifier reads
    tag = "R8"; cmd(8'h90);
    rd(5'd0, 2); rd(5'd1, 2);
    tag = "R9";
    blk_locked = 1; rd(5'd2, 2);
    blk_locked = 0; rd(5'd2, 2);
    rd(5'd3, 1); rd(5'd31, 1);
    tag = "R8"; cmd(8'h13); rd(5'd1, 1);        // still identifier
    tag = "R3"; cmd(8'h70); wsm_busy = 0; rd(5'd1, 2);
    tag = "R10"; cmd(8'hFF); array_data = 16'hBEEF; rd(5'd0, 2);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule